// File: doc/BRIEF.md
# Multicycle Processor Datapath Fabric

This block is the register-and-multiplexer fabric of a 16-bit multicycle processor. It holds no sequencing of its own: every register load, select and write-back comes from strobes that an external control unit drives in each cycle. Inside are a sixteen-entry register file, a program counter, a memory address register, a memory data register, an instruction register, an ALU result register, an immediate register, a status register for five flags, and the ALU itself: add, subtract and compare, bitwise logic, and shifts.

Register operands are addressed by the instruction register. The destination field is IR[11:8] and the source field is IR[3:0]. The write address is a separate input. Instruction and memory data come in on one read-data bus. The memory address register takes the ALU result, so the same ALU cycle that forms an address also loads it. A branch output evaluates the condition code in IR[11:8] against the stored flags. A synchronous clear zeroes every storage element, the register file included.

Top module: `mc_datapath`

## Requirements
- R1: While `clear` is high at a rising edge, every register becomes zero at that edge: the register file, PC, MAR, MDR, IR, ALU register, immediate register and status flags. This takes priority over every load enable.
- R2: `a_sel` picks ALU operand A. 00 selects the PC, 01 the register addressed by IR[11:8], 10 the register addressed by IR[3:0], and 11 the value zero.
- R3: `b_sel` picks ALU operand B. 0 selects the register addressed by IR[3:0] and 1 selects the immediate register.
- R4: With `alu_op`=00, the ALU adds or subtracts. When `add_en`=1 the 17-bit sum is A+B+`carry_in`. When `add_en`=0 it is A+~B+(1-`carry_in`), which is A-B-`carry_in`. The result is the low 16 bits. Carry C is bit 16 of the sum, and F is set on two's-complement overflow.
- R5: With `alu_op`=01, `log_op` picks the bitwise operation: 00 gives OR, 01 XOR, 10 AND, and 11 gives zero.
- R6: With `alu_op`=10 or 11, A is shifted by B[3:0] bit positions. B[4]=0 shifts left. B[4]=1 shifts right, filling with the sign bit when `shift_arith`=1 and with zeros otherwise.
- R7: The flag candidates compare A with B. Z is set when A equals B, L when A is below B unsigned, and N when A is below B signed. F and C are zero unless `alu_op`=00.
- R8: The flags Z, L, N, F and C are captured only at an edge where `psr_we` is high. Otherwise they hold.
- R9: When `rf_we` is high, the write-back value is written to the register addressed by `wr_addr`. `wb_sel`=0 selects the ALU register as that value and `wb_sel`=1 selects the MDR. When `rf_we` is low, no register changes.
- R10: Each register loads only when its own enable is high. PC and MAR load the ALU result. IR and MDR load `mem_rdata`. The ALU register loads the ALU result, except when `is_cmp` is high, in which case it holds.
- R11: `imm_kind` sets what the immediate register loads. 00 and 01 give IR[7:0] sign-extended, 10 gives IR[3:0] sign-extended, and 11 gives 0x0001.
- R12: `branch_taken` evaluates IR[11:8] against the stored flags. Code 0 gives Z, 1 gives not Z, 2 gives L, 3 gives N, 15 gives 1, and every other code gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| clear | input | 1 | Synchronous clear of all state |
| alu_op | input | 2 | ALU class: arithmetic, logic, shift, shift |
| log_op | input | 2 | Logic operation select |
| shift_arith | input | 1 | Right shifts fill with the sign bit |
| carry_in | input | 1 | Carry or borrow into add/subtract |
| add_en | input | 1 | 1 adds, 0 subtracts |
| is_cmp | input | 1 | Compare only; ALU register holds |
| psr_we | input | 1 | Status flag capture enable |
| a_sel | input | 2 | Operand A source |
| b_sel | input | 1 | Operand B source |
| wb_sel | input | 1 | Write-back source: ALU register or MDR |
| imm_kind | input | 2 | Immediate extension kind |
| rf_we | input | 1 | Register file write enable |
| wr_addr | input | 4 | Register file write address |
| ld_pc | input | 1 | PC load enable |
| ld_mar | input | 1 | MAR load enable |
| ld_mdr | input | 1 | MDR load enable |
| ld_ir | input | 1 | IR load enable |
| ld_alu | input | 1 | ALU register load enable |
| ld_imm | input | 1 | Immediate register load enable |
| mem_rdata | input | 16 | Data from memory |
| ir_out | output | 16 | Instruction register |
| mar_out | output | 16 | Memory address register |
| flag_z | output | 1 | Stored equal flag |
| flag_l | output | 1 | Stored unsigned-less flag |
| flag_n | output | 1 | Stored signed-less flag |
| flag_f | output | 1 | Stored overflow flag |
| flag_c | output | 1 | Stored carry flag |
| branch_taken | output | 1 | Branch condition result |

## Verification
Operand pairs loaded into two registers are run through every ALU class. Adds are tried with and without carry-in, and subtracts with and without borrow. Other pairs sit at the signed and unsigned boundaries, such as 0x7FFF+1 and 0x8000-1, so the signed and unsigned less-than flags differ and overflow is told apart from carry. Logic patterns with interleaved bits show OR, XOR and AND apart. A negative operand shifted right shows logical fill apart from arithmetic fill. Further directed sequences cover the following:
- the zero and PC choices for operand A;
- write-back from both sources;
- the enables that hold state, and the compare-only hold;
- each immediate kind with positive and negative fields;
- branch codes under two different stored flag sets;
- clear racing a load.

// File: rtl/mc_datapath.sv
module mc_datapath #(
  parameter int W    = 16,
  parameter int NREG = 16
) (
  input  logic             clk,
  input  logic             clear,
  input  logic [1:0]       alu_op,
  input  logic [1:0]       log_op,
  input  logic             shift_arith,
  input  logic             carry_in,
  input  logic             add_en,
  input  logic             is_cmp,
  input  logic             psr_we,
  input  logic [1:0]       a_sel,
  input  logic             b_sel,
  input  logic             wb_sel,
  input  logic [1:0]       imm_kind,
  input  logic             rf_we,
  input  logic [3:0]       wr_addr,
  input  logic             ld_pc,
  input  logic             ld_mar,
  input  logic             ld_mdr,
  input  logic             ld_ir,
  input  logic             ld_alu,
  input  logic             ld_imm,
  input  logic [W-1:0]     mem_rdata,
  output logic [W-1:0]     ir_out,
  output logic [W-1:0]     mar_out,
  output logic             flag_z,
  output logic             flag_l,
  output logic             flag_n,
  output logic             flag_f,
  output logic             flag_c,
  output logic             branch_taken
);
  localparam int SHW = $clog2(W);

  logic [W-1:0] rf [NREG];
  logic [W-1:0] pc, mdr, ir, alu_q, imm;
  logic [4:0]   psr;

  logic [W-1:0] rdst, rsrc, op_a, op_b, alu_y, shifted, logic_y, imm_next, wb;
  logic [W:0]   sum;
  logic         ovf, arith, shr;
  logic [SHW-1:0] amt;
  logic [3:0]   cond;

  assign rdst = rf[ir[11:8]];
  assign rsrc = rf[ir[3:0]];

  always_comb begin
    case (a_sel)
      2'b00:   op_a = pc;
      2'b01:   op_a = rdst;
      2'b10:   op_a = rsrc;
      default: op_a = '0;
    endcase
  end

  assign op_b = b_sel ? imm : rsrc;

  assign sum = add_en ? ({1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in})
                      : ({1'b0, op_a} + {1'b0, ~op_b} + {{W{1'b0}}, ~carry_in});

  assign ovf = add_en ? (op_a[W-1] == op_b[W-1]) && (sum[W-1] != op_a[W-1])
                      : (op_a[W-1] != op_b[W-1]) && (sum[W-1] != op_a[W-1]);

  always_comb begin
    case (log_op)
      2'b00:   logic_y = op_a | op_b;
      2'b01:   logic_y = op_a ^ op_b;
      2'b10:   logic_y = op_a & op_b;
      default: logic_y = '0;
    endcase
  end

  assign amt = op_b[SHW-1:0];
  assign shr = op_b[SHW];

  always_comb begin
    if (!shr)             shifted = op_a << amt;
    else if (shift_arith) shifted = W'($signed(op_a) >>> amt);
    else                  shifted = op_a >> amt;
  end

  assign arith = (alu_op == 2'b00);

  always_comb begin
    case (alu_op)
      2'b00:   alu_y = sum[W-1:0];
      2'b01:   alu_y = logic_y;
      default: alu_y = shifted;
    endcase
  end

  always_comb begin
    case (imm_kind)
      2'b10:   imm_next = {{(W-4){ir[3]}}, ir[3:0]};
      2'b11:   imm_next = W'(1);
      default: imm_next = {{(W-8){ir[7]}}, ir[7:0]};
    endcase
  end

  assign wb = wb_sel ? mdr : alu_q;

  always_ff @(posedge clk) begin
    if (clear) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (rf_we) begin
      rf[wr_addr] <= wb;
    end
  end

  always_ff @(posedge clk) begin
    if (clear) begin
      pc      <= '0;
      mar_out <= '0;
      mdr     <= '0;
      ir      <= '0;
      alu_q   <= '0;
      imm     <= '0;
      psr     <= '0;
    end else begin
      if (ld_pc)              pc      <= alu_y;
      if (ld_mar)             mar_out <= alu_y;
      if (ld_mdr)             mdr     <= mem_rdata;
      if (ld_ir)              ir      <= mem_rdata;
      if (ld_alu && !is_cmp)  alu_q   <= alu_y;
      if (ld_imm)             imm     <= imm_next;
      if (psr_we)
        psr <= {op_a == op_b, op_a < op_b, $signed(op_a) < $signed(op_b),
                arith & ovf, arith & sum[W]};
    end
  end

  assign ir_out = ir;
  assign {flag_z, flag_l, flag_n, flag_f, flag_c} = psr;

  assign cond = ir[11:8];
  always_comb begin
    case (cond)
      4'd0:    branch_taken = flag_z;
      4'd1:    branch_taken = !flag_z;
      4'd2:    branch_taken = flag_l;
      4'd3:    branch_taken = flag_n;
      4'd15:   branch_taken = 1'b1;
      default: branch_taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/mc_datapath_checks.sv
module mc_datapath_checks (
  input logic        clk,
  input logic        clear,
  input logic        ld_ir,
  input logic        ld_mar,
  input logic        psr_we,
  input logic [15:0] mem_rdata,
  input logic [15:0] ir_out,
  input logic [15:0] mar_out,
  input logic [4:0]  flags,
  input logic        branch_taken
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | clear;

  assert_clear_R1: assert property (@(posedge clk)
    clear |=> (ir_out == '0 && mar_out == '0 && flags == '0));

  assert_ir_load_R10: assert property (@(posedge clk) disable iff (!armed || clear)
    ld_ir |=> ir_out == $past(mem_rdata));

  assert_ir_hold_R10: assert property (@(posedge clk) disable iff (!armed || clear)
    !ld_ir |=> $stable(ir_out));

  assert_mar_hold_R10: assert property (@(posedge clk) disable iff (!armed || clear)
    !ld_mar |=> $stable(mar_out));

  assert_psr_hold_R8: assert property (@(posedge clk) disable iff (!armed || clear)
    !psr_we |=> $stable(flags));

  assert_branch_always_R12: assert property (@(posedge clk) disable iff (!armed || clear)
    ir_out[11:8] == 4'hF |-> branch_taken);

  assert_branch_eq_R12: assert property (@(posedge clk) disable iff (!armed || clear)
    ir_out[11:8] == 4'h0 |-> branch_taken == flags[4]);

  assert_branch_ne_R12: assert property (@(posedge clk) disable iff (!armed || clear)
    ir_out[11:8] == 4'h1 |-> branch_taken != flags[4]);
endmodule

bind mc_datapath mc_datapath_checks u_checks (
  .clk(clk), .clear(clear), .ld_ir(ld_ir), .ld_mar(ld_mar), .psr_we(psr_we),
  .mem_rdata(mem_rdata), .ir_out(ir_out), .mar_out(mar_out),
  .flags({flag_z, flag_l, flag_n, flag_f, flag_c}), .branch_taken(branch_taken)
);

// File: tb/sim_mc_datapath.sv
module sim_mc_datapath;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic clear = 1'b1;
  logic [1:0] alu_op = '0, log_op = '0, a_sel = '0, imm_kind = '0;
  logic shift_arith = 0, carry_in = 0, add_en = 0, is_cmp = 0, psr_we = 0;
  logic b_sel = 0, wb_sel = 0, rf_we = 0;
  logic ld_pc = 0, ld_mar = 0, ld_mdr = 0, ld_ir = 0, ld_alu = 0, ld_imm = 0;
  logic [3:0] wr_addr = '0;
  logic [15:0] mem_rdata = '0;
  logic [15:0] ir_out, mar_out;
  logic flag_z, flag_l, flag_n, flag_f, flag_c, branch_taken;
  logic [4:0] flags;
  assign flags = {flag_z, flag_l, flag_n, flag_f, flag_c};

  mc_datapath u0 (.*);

  int errors = 0, checks = 0;
  bit done = 0;

  // op, lop, arith, cin, add, a, b, result, flags {z,l,n,f,c}
  localparam logic [59:0] VEC [15] = '{
    {2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 16'h1234, 16'h0001, 16'h1235, 5'b00000},
    {2'b00, 2'b00, 1'b0, 1'b1, 1'b1, 16'hFFFF, 16'h0001, 16'h0001, 5'b00101},
    {2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 16'h7FFF, 16'h0001, 16'h8000, 5'b00010},
    {2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 16'h0005, 16'h0005, 16'h0000, 5'b10001},
    {2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 16'h0003, 16'h0005, 16'hFFFE, 5'b01100},
    {2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 16'h8000, 16'h0001, 16'h7FFF, 5'b00111},
    {2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 16'h000A, 16'h0003, 16'h0006, 5'b00001},
    {2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 16'h00F0, 16'h0F0F, 16'h0FFF, 5'b01100},
    {2'b01, 2'b01, 1'b0, 1'b0, 1'b0, 16'hFF00, 16'h0FF0, 16'hF0F0, 5'b00100},
    {2'b01, 2'b10, 1'b0, 1'b0, 1'b0, 16'hFF00, 16'h0FF0, 16'h0F00, 5'b00100},
    {2'b01, 2'b11, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h1234, 16'h0000, 5'b10000},
    {2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 16'h0081, 16'h0004, 16'h0810, 5'b00000},
    {2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 16'h8010, 16'h0014, 16'h0801, 5'b00100},
    {2'b10, 2'b00, 1'b1, 1'b0, 1'b0, 16'h8010, 16'h0013, 16'hF002, 5'b00100},
    {2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 16'h0003, 16'h000F, 16'h8000, 5'b01100}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle;
    clear = 0; alu_op = 0; log_op = 0; shift_arith = 0; carry_in = 0; add_en = 0;
    is_cmp = 0; psr_we = 0; a_sel = 0; b_sel = 0; wb_sel = 0; imm_kind = 0;
    rf_we = 0; wr_addr = 0; ld_pc = 0; ld_mar = 0; ld_mdr = 0; ld_ir = 0;
    ld_alu = 0; ld_imm = 0;
  endtask

  task automatic load_ir(input logic [15:0] v);
    idle; mem_rdata = v; ld_ir = 1; tick; idle;
  endtask

  task automatic write_reg(input logic [3:0] addr, input logic [15:0] v);
    idle; mem_rdata = v; ld_mdr = 1; tick;
    idle; wb_sel = 1; rf_we = 1; wr_addr = addr; tick; idle;
  endtask

  task automatic run(input logic [1:0] op, input logic [1:0] lop, input logic ar,
                     input logic cin, input logic add, input logic [1:0] as,
                     input logic bs, input logic psr);
    idle;
    alu_op = op; log_op = lop; shift_arith = ar; carry_in = cin; add_en = add;
    a_sel = as; b_sel = bs; psr_we = psr; ld_mar = 1;
    tick; idle;
  endtask

  task automatic read_reg(input logic [3:0] r);
    load_ir({4'h0, r, 8'h00});
    run(2'b01, 2'b00, 0, 0, 0, 2'b01, 0, 0);
  endtask

  task automatic load_imm(input logic [1:0] kind);
    idle; imm_kind = kind; ld_imm = 1; tick; idle;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); clear = 1; tick; idle;
    chk("R1 ir after clear", ir_out, 16'h0);
    chk("R1 mar after clear", mar_out, 16'h0);
    chk("R1 flags after clear", {11'h0, flags}, 16'h0);
    chk("R12 cond0 with Z=0", {15'h0, branch_taken}, 16'h0);

    load_ir(16'h0102);
    for (int i = 0; i < 15; i++) begin
      logic [59:0] v;
      string req;
      v = VEC[i];
      req = (v[59:58] == 2'b00) ? "R4" : (v[59:58] == 2'b01) ? "R5" : "R6";
      write_reg(4'd1, v[52:37]);
      write_reg(4'd2, v[36:21]);
      run(v[59:58], v[57:56], v[55], v[54], v[53], 2'b01, 1'b0, 1'b1);
      chk(req, mar_out, v[20:5]);
      chk("R7 flags", {11'h0, flags}, {11'h0, v[4:0]});
    end

    // R2: operand A from source register and from zero; R3 source register as B
    write_reg(4'd1, 16'h0003);
    write_reg(4'd2, 16'h0005);
    run(2'b00, 2'b00, 0, 0, 1, 2'b10, 0, 0);
    chk("R2 a_sel=10 src+src", mar_out, 16'h000A);
    run(2'b00, 2'b00, 0, 0, 1, 2'b11, 0, 0);
    chk("R2 a_sel=11 zero+src", mar_out, 16'h0005);

    // R8: flags hold without psr_we (last captured: 3 vs 5 -> L,N set)
    run(2'b00, 2'b00, 0, 0, 0, 2'b01, 0, 1);
    chk("R7 3 vs 5", {11'h0, flags}, 16'h000C);
    write_reg(4'd1, 16'h0005);
    run(2'b00, 2'b00, 0, 0, 0, 2'b01, 0, 0);
    chk("R8 flags held", {11'h0, flags}, 16'h000C);

    // R12 with L=1,N=1,Z=0
    load_ir(16'h0200); chk("R12 cond2 L", {15'h0, branch_taken}, 16'h1);
    load_ir(16'h0300); chk("R12 cond3 N", {15'h0, branch_taken}, 16'h1);
    load_ir(16'h0100); chk("R12 cond1 !Z", {15'h0, branch_taken}, 16'h1);
    load_ir(16'h0000); chk("R12 cond0 Z", {15'h0, branch_taken}, 16'h0);
    // equal operands: Z=1, L=0, N=0
    load_ir(16'h0102);
    run(2'b00, 2'b00, 0, 0, 0, 2'b01, 0, 1);
    chk("R7 5 vs 5", {11'h0, flags}, 16'h0011);
    load_ir(16'h0000); chk("R12 cond0 Z", {15'h0, branch_taken}, 16'h1);
    load_ir(16'h0100); chk("R12 cond1 !Z", {15'h0, branch_taken}, 16'h0);
    load_ir(16'h0200); chk("R12 cond2 L", {15'h0, branch_taken}, 16'h0);
    load_ir(16'h0F00); chk("R12 cond15", {15'h0, branch_taken}, 16'h1);
    load_ir(16'h0500); chk("R12 cond5", {15'h0, branch_taken}, 16'h0);

    // R9/R10: ALU register write-back, compare holds ALU register
    write_reg(4'd1, 16'h0003);
    load_ir(16'h0102);
    idle; alu_op = 2'b00; add_en = 1; a_sel = 2'b01; ld_alu = 1; tick; idle;
    idle; wb_sel = 0; rf_we = 1; wr_addr = 4'd3; tick; idle;
    read_reg(4'd3);
    chk("R9 wb from ALU reg", mar_out, 16'h0008);
    load_ir(16'h0102);
    idle; alu_op = 2'b00; add_en = 0; is_cmp = 1; a_sel = 2'b01; ld_alu = 1; tick; idle;
    idle; wb_sel = 0; rf_we = 1; wr_addr = 4'd3; tick; idle;
    read_reg(4'd3);
    chk("R10 is_cmp holds ALU reg", mar_out, 16'h0008);
    idle; mem_rdata = 16'hAAAA; ld_mdr = 1; tick;
    idle; wb_sel = 1; rf_we = 0; wr_addr = 4'd3; tick; idle;
    read_reg(4'd3);
    chk("R9 no write when rf_we=0", mar_out, 16'h0008);

    // R10: IR holds without ld_ir
    idle; mem_rdata = 16'h5A5A; tick;
    chk("R10 ir hold", ir_out, 16'h0300);

    // R11 immediates, R3 immediate as B
    load_ir(16'h01F5);
    load_imm(2'b00); run(2'b00, 2'b00, 0, 0, 1, 2'b11, 1, 0);
    chk("R11 kind00 neg", mar_out, 16'hFFF5);
    load_imm(2'b01); run(2'b00, 2'b00, 0, 0, 1, 2'b11, 1, 0);
    chk("R11 kind01", mar_out, 16'hFFF5);
    load_imm(2'b10); run(2'b00, 2'b00, 0, 0, 1, 2'b11, 1, 0);
    chk("R11 kind10 pos", mar_out, 16'h0005);
    load_ir(16'h010A);
    load_imm(2'b10); run(2'b00, 2'b00, 0, 0, 1, 2'b11, 1, 0);
    chk("R11 kind10 neg", mar_out, 16'hFFFA);
    load_imm(2'b11); run(2'b00, 2'b00, 0, 0, 1, 2'b11, 1, 0);
    chk("R11 kind11 one", mar_out, 16'h0001);

    // R2/R10: PC load and PC as operand A
    idle; alu_op = 2'b00; add_en = 1; a_sel = 2'b11; b_sel = 1; ld_pc = 1; tick; idle;
    run(2'b00, 2'b00, 0, 0, 1, 2'b00, 1, 0);
    chk("R2 a_sel=00 pc+1", mar_out, 16'h0002);

    // R1: clear beats loads and wipes register file
    write_reg(4'd5, 16'h7777);
    read_reg(4'd5);
    chk("R9 r5 written", mar_out, 16'h7777);
    idle; mem_rdata = 16'h1234; ld_ir = 1; ld_mar = 1; psr_we = 1; clear = 1; tick; idle;
    chk("R1 clear beats ld_ir", ir_out, 16'h0);
    chk("R1 clear beats ld_mar", mar_out, 16'h0);
    chk("R1 clear beats psr_we", {11'h0, flags}, 16'h0);
    read_reg(4'd5);
    chk("R1 register file wiped", mar_out, 16'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule